// File: doc/BRIEF.md
# Destination Address Hash Filter

This block screens the destination address of a received frame against a 64-entry hash table. The 48-bit address is folded into a 6-bit index. The index picks one bit of the table, and that bit, gated by an enable for the address class, decides acceptance. The class is unicast or multicast and is given by address bit 0. Software loads the table one 32-bit word at a time through a write port. Two override inputs, an exact-address hit from a neighbouring comparator and a copy-all configuration bit, force acceptance whatever the hash says.

Each lookup is presented as a 48-bit address with a one-cycle valid strobe. The verdict appears one cycle later, together with a result-valid flag and the class of the address. The decision logic is a two-state machine. In `ST_IDLE` no result is shown. `ST_RESULT` presents the registered verdict. Both states go to `ST_RESULT` when the valid strobe is high at a clock edge, and to `ST_IDLE` when it is low.

Top module: `addr_hash_filter`

## Requirements
- R1: Index bit n (0 to 5) is the XOR of address bits n, n+6, n+12, ..., n+42, where address bit 0 is the first bit received.
- R2: A table write with `cfg_wr_sel`=0 loads table bits 31..0, and one with `cfg_wr_sel`=1 loads bits 63..32. The index addresses table bit `index`, so indices 0 to 31 fall in the word selected by 0.
- R3: An address with bit 0 = 1 gives a hash match only when `mcast_en` is 1 and the indexed table bit is 1.
- R4: An address with bit 0 = 0 gives a hash match only when `ucast_en` is 1 and the indexed table bit is 1.
- R5: With `copy_all` = 1, every looked-up address reports `match` = 1.
- R6: With `exact_hit` = 1 during the lookup, `match` = 1 whatever the hash result.
- R7: `match_valid` is 1 in exactly the cycle after each cycle in which `da_valid` is 1. While `match_valid` is 0, `match` and `is_mcast` are 0. Back-to-back strobes give back-to-back results.
- R8: After reset the table holds all zeros and all outputs are 0, so no hash lookup matches until the table is written.
- R9: A table write and a lookup in the same cycle: the lookup sees the table contents from before the write.
- R10: `is_mcast` reports address bit 0 of the lookup whose result is shown.
- R11: With every table bit set and `mcast_en` = 1 (`ucast_en` = 0), every multicast address matches and no unicast address does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Table word write strobe |
| cfg_wr_sel | input | 1 | Word select: 0 = bits 31..0, 1 = bits 63..32 |
| cfg_wr_data | input | 32 | Word written into the table |
| ucast_en | input | 1 | Enable hash acceptance of unicast addresses |
| mcast_en | input | 1 | Enable hash acceptance of multicast addresses |
| copy_all | input | 1 | Accept every frame |
| exact_hit | input | 1 | Exact-address match from outside, forces acceptance |
| da_valid | input | 1 | Lookup strobe |
| da | input | 48 | Destination address, bit 0 received first |
| match_valid | output | 1 | Result valid, one cycle after `da_valid` |
| match | output | 1 | Frame accepted |
| is_mcast | output | 1 | Looked-up address was multicast |

## Verification
A table write and a lookup can fall in the same clock edge. The write then lands just as the lookup reads the bit it changes. The bench provokes this by writing all ones into a word while it looks up an address that indexes into that word. It expects no match in that cycle and a match on a repeat of the lookup in the next cycle. In a randomized phase, writes, strobes and enable changes overlap freely. A behavioural model, which updates its table only after it has computed each verdict, judges every cycle.

// File: rtl/afh_pkg.sv
package afh_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } dec_state_e;

    typedef struct packed {
        logic accept;
        logic mcast;
    } dec_result_t;

endpackage

// File: rtl/afh_fold.sv
module afh_fold #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  index
);

    for (genvar n = 0; n < IDX_W; n++) begin : g_idx
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int k = n; k < ADDR_W; k += IDX_W) begin
                acc = acc ^ addr[k];
            end
        end
        assign index[n] = acc;
    end

endmodule

// File: rtl/afh_table.sv
module afh_table #(
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32,
    localparam int TBL_W   = 1 << IDX_W,
    localparam int N_WORDS = TBL_W / WORD_W,
    localparam int SEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_index,
    output logic              rd_bit
);

    logic [N_WORDS-1:0][WORD_W-1:0] words_q;
    logic [TBL_W-1:0]               flat;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[w] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(w))) begin
                words_q[w] <= wr_data;
            end
        end
    end

    assign flat   = words_q;
    assign rd_bit = flat[rd_index];

endmodule

// File: rtl/afh_decide.sv
module afh_decide
    import afh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lookup,
    input  logic addr_lsb,
    input  logic table_bit,
    input  logic ucast_en,
    input  logic mcast_en,
    input  logic copy_all,
    input  logic exact_hit,
    output logic res_valid,
    output logic res_match,
    output logic res_mcast
);

    dec_state_e  state_q, state_d;
    dec_result_t res_q, res_d;
    logic        class_en;

    always_comb begin
        class_en      = addr_lsb ? mcast_en : ucast_en;
        res_d.mcast   = addr_lsb;
        res_d.accept  = copy_all | exact_hit | (table_bit & class_en);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = lookup ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = lookup ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            res_q   <= lookup ? res_d : '0;
        end
    end

    always_comb begin
        res_valid = 1'b0;
        res_match = 1'b0;
        res_mcast = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESULT: begin
                res_valid = 1'b1;
                res_match = res_q.accept;
                res_mcast = res_q.mcast;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32,
    localparam int TBL_W   = 1 << IDX_W,
    localparam int N_WORDS = TBL_W / WORD_W,
    localparam int SEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic              ucast_en,
    input  logic              mcast_en,
    input  logic              copy_all,
    input  logic              exact_hit,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da,
    output logic              match_valid,
    output logic              match,
    output logic              is_mcast
);

    logic [IDX_W-1:0] hash_idx;
    logic             hash_bit;

    afh_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold (
        .addr  (da),
        .index (hash_idx)
    );

    afh_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wr_data),
        .rd_index (hash_idx),
        .rd_bit   (hash_bit)
    );

    afh_decide u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .lookup    (da_valid),
        .addr_lsb  (da[0]),
        .table_bit (hash_bit),
        .ucast_en  (ucast_en),
        .mcast_en  (mcast_en),
        .copy_all  (copy_all),
        .exact_hit (exact_hit),
        .res_valid (match_valid),
        .res_match (match),
        .res_mcast (is_mcast)
    );

endmodule

// File: rtl/addr_hash_filter_chk.sv
module addr_hash_filter_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ucast_en,
    input logic              mcast_en,
    input logic              copy_all,
    input logic              exact_hit,
    input logic              da_valid,
    input logic [ADDR_W-1:0] da,
    input logic              match_valid,
    input logic              match,
    input logic              is_mcast
);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid == $past(da_valid)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid |-> (!match && !is_mcast)); // R7

    AST_CLASS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> (is_mcast == $past(da[0]))); // R10

    AST_COPY_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && copy_all) |=> match); // R5

    AST_EXACT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && exact_hit) |=> match); // R6

    AST_MC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && da[0] && !mcast_en && !copy_all && !exact_hit) |=> !match); // R3

    AST_UC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !da[0] && !ucast_en && !copy_all && !exact_hit) |=> !match); // R4

endmodule

bind addr_hash_filter addr_hash_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ucast_en    (ucast_en),
    .mcast_en    (mcast_en),
    .copy_all    (copy_all),
    .exact_hit   (exact_hit),
    .da_valid    (da_valid),
    .da          (da),
    .match_valid (match_valid),
    .match       (match),
    .is_mcast    (is_mcast)
);

// File: tb/addr_hash_filter_tb.sv
`timescale 1ns/1ps
module addr_hash_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [0:0]  cfg_wr_sel;
    logic [31:0] cfg_wr_data;
    logic        ucast_en, mcast_en, copy_all, exact_hit;
    logic        da_valid;
    logic [47:0] da;
    logic        match_valid, match, is_mcast;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [63:0] m_tbl;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
    logic        exp_v, exp_m, exp_c;

    always #2.5 clk = ~clk;

    addr_hash_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .ucast_en(ucast_en), .mcast_en(mcast_en), .copy_all(copy_all), .exact_hit(exact_hit),
        .da_valid(da_valid), .da(da),
        .match_valid(match_valid), .match(match), .is_mcast(is_mcast)
    );

    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [5:0] r = '0;
        for (int i = 0; i < 48; i++) r[i % 6] = r[i % 6] ^ a[i];
        return r;
    endfunction

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic compare(input string tag);
        n_checks++;
        if ({match_valid, match, is_mcast} !== {exp_v, exp_m, exp_c}) begin
            n_errors++;
            $display("FAIL %s: actual valid/match/mcast=%b%b%b expected=%b%b%b at %0t",
                     tag, match_valid, match, is_mcast, exp_v, exp_m, exp_c, $time);
        end
    endtask

    // one clock: inputs applied now (at a falling edge), result checked at the next falling edge
    task automatic cycle(input logic v, input logic [47:0] a, input logic we,
                         input logic sel, input logic [31:0] wd, input string tag);
        logic hit;
        da_valid = v; da = a; cfg_wr_en = we; cfg_wr_sel = sel; cfg_wr_data = wd;
        @(posedge clk);
        hit   = m_tbl[ref_index(a)];
        exp_v = v;
        exp_c = v & a[0];
        exp_m = v & (copy_all | exact_hit | (hit & (a[0] ? mcast_en : ucast_en)));
        if (we) begin
            if (sel) m_tbl[63:32] = wd;
            else     m_tbl[31:0]  = wd;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R7 watchdog: actual=still running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = '0;
        ucast_en = 0; mcast_en = 0; copy_all = 0; exact_hit = 0;
        da_valid = 0; da = '0; m_tbl = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        exp_v = 0; exp_m = 0; exp_c = 0;
        compare("R8 reset outputs");

        // R8: empty table after reset, both enables on
        ucast_en = 1; mcast_en = 1;
        cycle(1, 48'h0000_0000_0001, 0, 0, '0, "R8 empty table mcast");
        cycle(1, 48'h0000_0000_1000, 0, 0, '0, "R8 empty table ucast");
        cycle(0, '0, 0, 0, '0, "R7 idle");

        // R1/R2: single table bit 2 in the low word; bit 13 folds to index 2
        cycle(0, '0, 1, 0, 32'h0000_0004, "R2 write low");
        cycle(1, 48'h0000_0000_2000, 0, 0, '0, "R1 bit13 -> index2 ucast");
        cycle(1, 48'h0000_0000_1000, 0, 0, '0, "R1 bit12 -> index1 no hit");
        // bits 5 and 11 both fold to index bit5 and cancel
        cycle(1, 48'h0000_0000_0820, 0, 0, '0, "R1 cancel pair");
        // R2: high word bit 0 = index 32 (index bit5 only: da bit 47)
        cycle(0, '0, 1, 1, 32'h0000_0001, "R2 write high");
        cycle(1, 48'h8000_0000_0000, 0, 0, '0, "R2 index32 ucast");
        cycle(1, 48'h8000_0000_0001, 0, 0, '0, "R2 index33 miss");
        cycle(1, 48'h8000_0000_0041, 0, 0, '0, "R2 index32 mcast");

        // R3/R4: class enables
        mcast_en = 0;
        cycle(1, 48'h8000_0000_0041, 0, 0, '0, "R3 mcast disabled");
        cycle(1, 48'h8000_0000_0000, 0, 0, '0, "R4 ucast still on");
        mcast_en = 1; ucast_en = 0;
        cycle(1, 48'h8000_0000_0000, 0, 0, '0, "R4 ucast disabled");
        cycle(1, 48'h8000_0000_0041, 0, 0, '0, "R3 mcast on");

        // R5/R6: overrides with hash disabled
        ucast_en = 0; mcast_en = 0; copy_all = 1;
        cycle(1, 48'h1234_5678_9ABC, 0, 0, '0, "R5 copy all ucast");
        cycle(1, 48'h1234_5678_9ABD, 0, 0, '0, "R5 copy all mcast");
        copy_all = 0; exact_hit = 1;
        cycle(1, 48'h0A0B_0C0D_0E0E, 0, 0, '0, "R6 exact hit");
        exact_hit = 0;
        cycle(1, 48'h0A0B_0C0D_0E0E, 0, 0, '0, "R6 exact released");

        // R9: write and lookup in the same edge
        cycle(0, '0, 1, 0, 32'h0000_0000, "R9 clear low");
        cycle(0, '0, 1, 1, 32'h0000_0000, "R9 clear high");
        mcast_en = 1;
        cycle(1, 48'h0000_0000_0001, 1, 0, 32'hFFFF_FFFF, "R9 same-edge old contents");
        cycle(1, 48'h0000_0000_0001, 0, 0, '0, "R9 next edge new contents");

        // R11: all ones, multicast only; R7 back-to-back strobes
        ucast_en = 0;
        cycle(0, '0, 1, 1, 32'hFFFF_FFFF, "R11 fill high");
        for (int i = 0; i < 24; i++) begin
            seed = next_rand(seed);
            cycle(1, {seed[47:1], 1'b1}, 0, 0, '0, "R11 every mcast");
            cycle(1, {seed[47:1], 1'b0}, 0, 0, '0, "R11 no ucast");
        end
        cycle(0, '0, 0, 0, '0, "R7 strobe low");

        // mixed random traffic: R3 R4 R10 R7 R9 together
        for (int i = 0; i < 400; i++) begin
            seed = next_rand(seed);
            ucast_en  = seed[50];
            mcast_en  = seed[51];
            copy_all  = (seed[55:52] == 4'h0);
            exact_hit = (seed[59:56] == 4'h0);
            cycle(seed[60], seed[47:0], seed[61] & seed[62], seed[63],
                  seed[31:0] ^ seed[63:32], "R10 random mix");
        end
        copy_all = 0; exact_hit = 0;
        cycle(0, '0, 0, 0, '0, "R7 final idle");
        finish_run();
    end

endmodule